// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block gathers the interrupt causes of a 16550-style serial controller, ranks them and drives one interrupt request line. It also forms the 8-bit identification value that the host reads to learn which cause currently has the highest rank. The surrounding controller supplies status flags, single-cycle event pulses and the host's register access strobes. The identification value is combinational from the block's state, so the host sees it in the same cycle as its read strobe.

Line errors and modem line changes arrive as one-cycle pulses, one bit per condition, and are held inside the block until the host reads the register that owns them. The receive data condition is a level that the receive FIFO keeps up to date. The character timeout and the transmit-empty condition are held as events. A read of the identification value clears the transmit-empty event only when that read reported it.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with every input low, the identification value is 8'h01 and `irq` is low.
- R2: Bit 0 of `iir` is 0 when a cause is reported and 1 when none is reported. Bits 5:4 always read 0. Bits 7:6 both equal `fifo_en`.
- R3: The low nibble is 4'b0110 for line status, 4'b0100 for receive data, 4'b1100 for character timeout, 4'b0010 for transmit empty and 4'b0000 for modem status. Line status ranks above the receive group, which ranks above transmit empty, which ranks above modem status. Within the receive group, receive data ranks above timeout.
- R4: A pulse on any bit of `ls_evt` latches the line status cause. The edge with `rd_lsr` high clears it. An event in the same cycle as the read wins.
- R5: While `rx_avail` is high and enabled, the receive data cause is reported as 4'b0100. It is not latched.
- R6: A rising edge of `rx_tmo` while `fifo_en` is high latches the timeout cause, reported with bit 3 set. `rd_rbr` clears it. With `fifo_en` low, `rx_tmo` has no effect and bit 3 stays 0.
- R7: The transmit-empty cause latches on a rising edge of `thr_empty`, and also when `en_thr` goes from 0 to 1 while `thr_empty` is high. A `thr_empty` that is high in the first cycle after reset counts as a rising edge.
- R8: `wr_thr` clears the transmit-empty cause. `rd_iir` clears it only if the value presented during that read carried code 4'b0010. A read showing another code leaves it pending.
- R9: A pulse on any bit of `mdm_evt` latches the modem status cause. `rd_msr` clears it.
- R10: A cause whose enable bit is low is absent from `irq` and `iir`. A latched cause stays held and appears once its enable is set.
- R11: `irq` is high exactly when at least one enabled cause is pending, which is exactly when `iir[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ls_evt | input | LS_W | One-cycle line error pulses: overrun, parity, framing, break |
| rx_avail | input | 1 | Receive data ready (one character, or trigger level in FIFO mode) |
| rx_tmo | input | 1 | Receive FIFO character timeout flag |
| thr_empty | input | 1 | Transmit holding register empty flag |
| mdm_evt | input | MDM_W | One-cycle modem line change pulses |
| fifo_en | input | 1 | FIFO mode enable |
| en_ls | input | 1 | Line status interrupt enable |
| en_rx | input | 1 | Receive data and timeout interrupt enable |
| en_thr | input | 1 | Transmit-empty interrupt enable |
| en_mdm | input | 1 | Modem status interrupt enable |
| rd_iir | input | 1 | Host read of the identification value |
| rd_lsr | input | 1 | Host read of line status |
| rd_rbr | input | 1 | Host read of the receive buffer |
| rd_msr | input | 1 | Host read of modem status |
| wr_thr | input | 1 | Host write of the transmit holding register |
| irq | output | 1 | Interrupt request, active high |
| iir | output | 8 | Identification value |

## Verification
The bench builds the block with LS_W = 4 and MDM_W = 4. At these widths every individual line error and modem change bit can be driven, including the same-cycle set-and-clear case. The tests stack all four causes at once and peel them off one at a time, so every step of the ranking is visited. They also cover both kinds of identification read: one that reports transmit empty and one that reports a higher cause while transmit empty waits underneath.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int LS_W  = 4,
  parameter int MDM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LS_W-1:0]  ls_evt,
  input  logic             rx_avail,
  input  logic             rx_tmo,
  input  logic             thr_empty,
  input  logic [MDM_W-1:0] mdm_evt,
  input  logic             fifo_en,
  input  logic             en_ls,
  input  logic             en_rx,
  input  logic             en_thr,
  input  logic             en_mdm,
  input  logic             rd_iir,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic             irq,
  output logic [7:0]       iir
);

  localparam logic [3:0] CODE_NONE = 4'b0001;
  localparam logic [3:0] CODE_LS   = 4'b0110;
  localparam logic [3:0] CODE_RX   = 4'b0100;
  localparam logic [3:0] CODE_TMO  = 4'b1100;
  localparam logic [3:0] CODE_THR  = 4'b0010;
  localparam logic [3:0] CODE_MDM  = 4'b0000;

  logic ls_p, tmo_p, thr_p, mdm_p;
  logic thr_q, en_thr_q, tmo_q;
  logic [3:0] code;

  wire ls_set  = |ls_evt;
  wire mdm_set = |mdm_evt;
  wire tmo_set = fifo_en & rx_tmo & ~tmo_q;
  wire thr_set = thr_empty & (~thr_q | (en_thr & ~en_thr_q));

  wire ls_on  = en_ls & ls_p;
  wire rx_on  = en_rx & rx_avail;
  wire tmo_on = en_rx & fifo_en & tmo_p;
  wire thr_on = en_thr & thr_p;
  wire mdm_on = en_mdm & mdm_p;

  always_comb begin
    if (ls_on)       code = CODE_LS;
    else if (rx_on)  code = CODE_RX;
    else if (tmo_on) code = CODE_TMO;
    else if (thr_on) code = CODE_THR;
    else if (mdm_on) code = CODE_MDM;
    else             code = CODE_NONE;
  end

  wire thr_ack = rd_iir & (code == CODE_THR);

  assign irq = ls_on | rx_on | tmo_on | thr_on | mdm_on;
  assign iir = {fifo_en, fifo_en, 2'b00, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_p     <= 1'b0;
      tmo_p    <= 1'b0;
      thr_p    <= 1'b0;
      mdm_p    <= 1'b0;
      thr_q    <= 1'b0;
      en_thr_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      ls_p     <= ls_set | (ls_p & ~rd_lsr);
      tmo_p    <= tmo_set | (tmo_p & fifo_en & ~rd_rbr);
      thr_p    <= thr_set | (thr_p & ~wr_thr & ~thr_ack);
      mdm_p    <= mdm_set | (mdm_p & ~rd_msr);
      thr_q    <= thr_empty;
      en_thr_q <= en_thr;
      tmo_q    <= rx_tmo;
    end
  end

  assert_irq_bit0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir[0]);

  assert_no_tmo_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !iir[3]);

  assert_ls_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && ls_evt == '0) |=> !ls_p);

  assert_ls_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ls && ls_p) |-> iir[3:0] == CODE_LS);

  assert_thr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !thr_set) |=> !thr_p);

  assert_mdm_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[3:0] == CODE_MDM) |-> !(ls_on || rx_on || tmo_on || thr_on));

  assert_mdm_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && mdm_evt == '0) |=> !mdm_p);

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ls_evt = '0;
  logic [3:0] mdm_evt = '0;
  logic rx_avail = 0, rx_tmo = 0, thr_empty = 0, fifo_en = 0;
  logic en_ls = 0, en_rx = 0, en_thr = 0, en_mdm = 0;
  logic rd_iir = 0, rd_lsr = 0, rd_rbr = 0, rd_msr = 0, wr_thr = 0;
  logic irq;
  logic [7:0] iir;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident #(.LS_W(4), .MDM_W(4)) u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ls_evt(ls_evt), .rx_avail(rx_avail),
    .rx_tmo(rx_tmo), .thr_empty(thr_empty), .mdm_evt(mdm_evt),
    .fifo_en(fifo_en), .en_ls(en_ls), .en_rx(en_rx), .en_thr(en_thr),
    .en_mdm(en_mdm), .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .rd_msr(rd_msr), .wr_thr(wr_thr), .irq(irq), .iir(iir));

  task automatic check(input string tag, input logic [7:0] exp);
    #1;
    checks++;
    if (iir !== exp) begin
      fails++;
      $display("FAIL %s: iir=%h expected %h", tag, iir, exp);
    end
    checks++;
    if (irq !== ~exp[0]) begin
      fails++;
      $display("FAIL R11 (%s): irq=%b expected %b", tag, irq, ~exp[0]);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset", 8'h01);
  endtask

  task automatic t_fifo_bits;
    tick(); fifo_en = 1;
    check("R2 fifo bits", 8'hC1);
    tick(); fifo_en = 0;
    check("R2 fifo bits off", 8'h01);
  endtask

  task automatic t_line;
    tick(); en_ls = 1; ls_evt = 4'b0100;
    tick(); ls_evt = 0;
    check("R4 line set", 8'h06);
    rd_lsr = 1; tick(); rd_lsr = 0;
    check("R4 line clear", 8'h01);
    ls_evt = 4'b0001; tick(); ls_evt = 0;
    rd_lsr = 1; ls_evt = 4'b1000; tick(); rd_lsr = 0; ls_evt = 0;
    check("R4 event beats read", 8'h06);
    rd_lsr = 1; tick(); rd_lsr = 0; en_ls = 0;
    check("R4 cleared again", 8'h01);
  endtask

  task automatic t_rx;
    tick(); en_rx = 1; rx_avail = 1;
    check("R5 rx data", 8'h04);
    rx_avail = 0;
    check("R5 rx gone", 8'h01);
  endtask

  task automatic t_tmo;
    tick(); fifo_en = 1; rx_tmo = 1;
    tick();
    check("R6 timeout", 8'hCC);
    rx_avail = 1;
    check("R3 rx over timeout", 8'hC4);
    rx_avail = 0; rd_rbr = 1; tick(); rd_rbr = 0;
    check("R6 timeout cleared", 8'hC1);
    rx_tmo = 0; tick(); fifo_en = 0;
    tick(); rx_tmo = 1; tick(); tick();
    check("R6 ignored w/o fifo", 8'h01);
    rx_tmo = 0; en_rx = 0;
  endtask

  task automatic t_thr;
    tick(); en_thr = 1; thr_empty = 1;
    tick();
    check("R7 thr edge", 8'h02);
    rd_iir = 1; tick(); rd_iir = 0;
    check("R8 iir read ack", 8'h01);
    thr_empty = 0; tick(); thr_empty = 1; tick();
    check("R7 thr edge again", 8'h02);
    wr_thr = 1; tick(); wr_thr = 0;
    check("R8 write clear", 8'h01);
    en_thr = 0; tick(); tick(); en_thr = 1; tick();
    check("R7 enable edge", 8'h02);
    en_ls = 1; ls_evt = 4'b0010; tick(); ls_evt = 0;
    rd_iir = 1; tick(); rd_iir = 0;
    check("R8 masked read keeps thr (line shown)", 8'h06);
    rd_lsr = 1; tick(); rd_lsr = 0;
    check("R8 thr survives other read", 8'h02);
    wr_thr = 1; thr_empty = 0; tick(); wr_thr = 0; en_thr = 0; en_ls = 0;
    check("R8 final clear", 8'h01);
  endtask

  task automatic t_mdm;
    tick(); en_mdm = 1; mdm_evt = 4'b1000; tick(); mdm_evt = 0;
    check("R9 modem set", 8'h00);
    rd_msr = 1; tick(); rd_msr = 0;
    check("R9 modem clear", 8'h01);
  endtask

  task automatic t_enable;
    tick(); en_mdm = 0; mdm_evt = 4'b0001; tick(); mdm_evt = 0;
    check("R10 disabled hidden", 8'h01);
    en_mdm = 1;
    check("R10 appears on enable", 8'h00);
    rd_msr = 1; tick(); rd_msr = 0; en_mdm = 0;
    check("R10 cleared", 8'h01);
  endtask

  task automatic t_priority;
    tick(); en_ls = 1; en_rx = 1; en_thr = 1; en_mdm = 1;
    ls_evt = 4'b0001; mdm_evt = 4'b0100; thr_empty = 1; rx_avail = 1;
    tick(); ls_evt = 0; mdm_evt = 0;
    check("R3 line first", 8'h06);
    rd_lsr = 1; tick(); rd_lsr = 0;
    check("R3 rx second", 8'h04);
    rx_avail = 0;
    check("R3 thr third", 8'h02);
    wr_thr = 1; thr_empty = 0; tick(); wr_thr = 0;
    check("R3 modem last", 8'h00);
    rd_msr = 1; tick(); rd_msr = 0;
    check("R3 all clear", 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fifo_bits();
    t_line();
    t_rx();
    t_tmo();
    t_thr();
    t_mdm();
    t_enable();
    t_priority();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule